// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Decoder with Zero Suppression

This block turns a row of N packed 4-bit hexadecimal codes into N groups of seven active-low segment lines for a common-anode display. Each digit position holds a blanking cell. A cell blanks its digit only when the digit's code is zero and the cell's blanking input is low. The cell's blanking output is high whenever the digit is shown, and it feeds the blanking input of the next cell along the chain.

A single mode input sets the direction of the chain. In leading mode the chain starts at the most significant digit and moves toward digit 0, so zeros in front of the first nonzero digit go dark. In trailing mode the chain starts at digit 0 and moves upward, so zeros after the last nonzero digit go dark. Either way, a zero that sits between nonzero digits stays visible. The block is purely combinational. Digit refresh, multiplexing and drive electronics are handled elsewhere.

Top module: `zblank_disp`

## Requirements
- R1: Segment lines are active low: a lit segment is 0. Each 7-bit group is ordered a (bit 6, top bar), then b, c, d, e, f clockwise, down to g (bit 0, centre bar). A blank digit is 7'b1111111 and a shown zero is 7'b0000001. Digit i uses code bits [4i+3:4i] and segment bits [7i+6:7i], and digit 0 is the least significant.
- R2: Codes 1 to 9 show these patterns: 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000 (with its top tail), 7=0001111, 8=0000000, 9=0000100 (with its bottom tail).
- R3: Codes A to F show these patterns: A=0001000, lowercase b=1100000, C=0110001, lowercase d=1000010, E=0110000, F=0111000.
- R4: A digit whose code is 0 and whose blanking input is 0 is blank, and its blanking output `rbo_o[i]` is 0.
- R5: A digit whose code is 0 and whose blanking input is 1 shows the zero glyph, and its blanking output is 1.
- R6: A digit with a nonzero code always shows its glyph and drives its blanking output to 1, whatever its blanking input.
- R7: With `trail_mode_i`=0 (leading mode), the most significant digit's blanking input is 0, and each digit's blanking output drives the blanking input of the next less significant digit.
- R8: With `trail_mode_i`=1 (trailing mode), digit 0's blanking input is 0, and each digit's blanking output drives the blanking input of the next more significant digit.
- R9: When every code is zero, every digit is blank and every blanking output is 0, in both modes.
- R10: A zero that lies between nonzero digits is shown in both modes. For example, 0x0904 in leading mode shows the digits 9, 0, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_i | input | 4*N | Packed hexadecimal codes, digit 0 in the low nibble |
| trail_mode_i | input | 1 | 0 suppresses leading zeros, 1 suppresses trailing zeros |
| seg_n_o | output | 7*N | Active-low segments, a..g per digit, MSB first |
| rbo_o | output | N | Blanking output of each digit's cell (1 = digit shown) |

## Verification
The block holds no state. A fault in a cell therefore shows up at once, on the same input pattern, as a digit that goes dark or lights up when it should not, and the matching `rbo_o` bit changes with it. A break in one link of the chain is harder to see. It shows up only on patterns where a run of zeros reaches that link from the chain's starting end. For that reason the vectors place zero runs of different lengths at both ends of the row, in both modes. A wrong glyph entry shows up only when its code is applied, so every code is swept through every position.

// File: rtl/zblank_pkg.sv
package zblank_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [CODE_W-1:0] code_t;
    localparam seg_t SEG_DARK = 7'b1111111;
endpackage

// File: rtl/zblank_glyph.sv
module zblank_glyph
    import zblank_pkg::*;
(
    input  code_t code_i,
    output seg_t  seg_n_o
);
    always_comb begin
        unique case (code_i)
            4'h0: seg_n_o = 7'b0000001;
            4'h1: seg_n_o = 7'b1001111;
            4'h2: seg_n_o = 7'b0010010;
            4'h3: seg_n_o = 7'b0000110;
            4'h4: seg_n_o = 7'b1001100;
            4'h5: seg_n_o = 7'b0100100;
            4'h6: seg_n_o = 7'b0100000;
            4'h7: seg_n_o = 7'b0001111;
            4'h8: seg_n_o = 7'b0000000;
            4'h9: seg_n_o = 7'b0000100;
            4'hA: seg_n_o = 7'b0001000;
            4'hB: seg_n_o = 7'b1100000;
            4'hC: seg_n_o = 7'b0110001;
            4'hD: seg_n_o = 7'b1000010;
            4'hE: seg_n_o = 7'b0110000;
            4'hF: seg_n_o = 7'b0111000;
            default: seg_n_o = SEG_DARK;
        endcase
    end

    // every code has a visible glyph; only the blanking path darkens a digit
    always_comb begin
        assert_glyph_visible_R1: assert (seg_n_o != SEG_DARK);
    end
endmodule

// File: rtl/zblank_cell.sv
module zblank_cell
    import zblank_pkg::*;
(
    input  code_t code_i,
    input  logic  rbi_i,
    output logic  rbo_o
);
    logic is_zero;
    assign is_zero = (code_i == '0);
    assign rbo_o   = rbi_i | ~is_zero;

    // blanked digit is zero with a low input
    always_comb begin
        if (!rbo_o) begin
            assert_dark_only_zero_R4: assert (code_i == '0 && !rbi_i);
        end
    end
endmodule

// File: rtl/zblank_disp.sv
module zblank_disp
    import zblank_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [CODE_W*N-1:0] digit_i,
    input  logic                trail_mode_i,
    output logic [SEG_W*N-1:0]  seg_n_o,
    output logic [N-1:0]        rbo_o
);
    localparam int MSD = N - 1;

    for (genvar i = 0; i < N; i++) begin : stage
        code_t code;
        seg_t  glyph;
        logic  lead_rbi, lead_rbo;
        logic  trail_rbi, trail_rbo;
        logic  shown;

        assign code = digit_i[CODE_W*i +: CODE_W];

        zblank_glyph u_glyph (.code_i(code), .seg_n_o(glyph));

        // chain running from most significant digit downward
        if (i == MSD) begin : lead_head
            assign lead_rbi = 1'b0;
        end else begin : lead_link
            assign lead_rbi = stage[i+1].lead_rbo;
        end

        // chain running from least significant digit upward
        if (i == 0) begin : trail_head
            assign trail_rbi = 1'b0;
        end else begin : trail_link
            assign trail_rbi = stage[i-1].trail_rbo;
        end

        zblank_cell u_lead  (.code_i(code), .rbi_i(lead_rbi),  .rbo_o(lead_rbo));
        zblank_cell u_trail (.code_i(code), .rbi_i(trail_rbi), .rbo_o(trail_rbo));

        assign shown = trail_mode_i ? trail_rbo : lead_rbo;
        assign seg_n_o[SEG_W*i +: SEG_W] = shown ? glyph : SEG_DARK;
        assign rbo_o[i] = shown;

        always_comb begin
            if (code != '0) begin
                assert_nonzero_lit_R6: assert (rbo_o[i] && seg_n_o[SEG_W*i +: SEG_W] != SEG_DARK);
            end
            if (!rbo_o[i]) begin
                assert_dark_pattern_R1: assert (seg_n_o[SEG_W*i +: SEG_W] == SEG_DARK);
            end
            if (!trail_mode_i && i == MSD && code == '0) begin
                assert_lead_head_dark_R7: assert (!rbo_o[i]);
            end
            if (trail_mode_i && i == 0 && code == '0) begin
                assert_trail_head_dark_R8: assert (!rbo_o[i]);
            end
        end
    end
endmodule

// File: tb/zblank_disp_bench.sv
module zblank_disp_bench;
    localparam int N = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [4*N-1:0] digit_i;
    logic           trail_mode_i;
    logic [7*N-1:0] seg_n_o;
    logic [N-1:0]   rbo_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    zblank_disp #(.N(N)) u_zblank_disp (
        .digit_i(digit_i), .trail_mode_i(trail_mode_i),
        .seg_n_o(seg_n_o), .rbo_o(rbo_o)
    );

    function automatic logic [6:0] ref_glyph(input logic [3:0] c);
        case (c)
            4'h0: return 7'b0000001; 4'h1: return 7'b1001111;
            4'h2: return 7'b0010010; 4'h3: return 7'b0000110;
            4'h4: return 7'b1001100; 4'h5: return 7'b0100100;
            4'h6: return 7'b0100000; 4'h7: return 7'b0001111;
            4'h8: return 7'b0000000; 4'h9: return 7'b0000100;
            4'hA: return 7'b0001000; 4'hB: return 7'b1100000;
            4'hC: return 7'b0110001; 4'hD: return 7'b1000010;
            4'hE: return 7'b0110000; default: return 7'b0111000;
        endcase
    endfunction

    task automatic apply(input logic mode, input logic [15:0] val);
        @(posedge clk);
        trail_mode_i = mode;
        digit_i      = val;
        @(negedge clk);
    endtask

    // compare every digit against expected shown-mask
    task automatic expect_row(input string tag, input logic [N-1:0] shown);
        logic [6:0] exp_seg;
        checks++;
        if (rbo_o !== shown) begin
            errors++;
            $display("FAIL %s rbo mode=%0b val=%h actual=%b expected=%b",
                     tag, trail_mode_i, digit_i, rbo_o, shown);
        end
        for (int i = 0; i < N; i++) begin
            exp_seg = shown[i] ? ref_glyph(digit_i[4*i +: 4]) : 7'b1111111;
            checks++;
            if (seg_n_o[7*i +: 7] !== exp_seg) begin
                errors++;
                $display("FAIL %s digit%0d mode=%0b val=%h actual=%b expected=%b",
                         tag, i, trail_mode_i, digit_i, seg_n_o[7*i +: 7], exp_seg);
            end
        end
    endtask

    // {mode, value, expected shown mask}
    localparam logic [20:0] VEC [14] = '{
        {1'b0, 16'h0904, 4'b0111}, {1'b1, 16'h0904, 4'b1111},
        {1'b0, 16'h0000, 4'b0000}, {1'b1, 16'h0000, 4'b0000},
        {1'b0, 16'h0050, 4'b0011}, {1'b1, 16'h0050, 4'b1110},
        {1'b0, 16'h1234, 4'b1111}, {1'b1, 16'hABCD, 4'b1111},
        {1'b0, 16'h0EF0, 4'b0111}, {1'b1, 16'h0EF0, 4'b1110},
        {1'b0, 16'h0006, 4'b0001}, {1'b1, 16'h9000, 4'b1000},
        {1'b0, 16'h5678, 4'b1111}, {1'b1, 16'h1000, 4'b1000}
    };

    initial begin
        digit_i = '0;
        trail_mode_i = 1'b0;
        // table walk: R7 for leading rows, R8 for trailing rows
        for (int k = 0; k < 14; k++) begin
            apply(VEC[k][20], VEC[k][19:4]);
            expect_row(VEC[k][20] ? "R8" : "R7", VEC[k][3:0]);
        end
        // R1: blank and shown-zero encodings
        apply(1'b0, 16'h0100);
        checks++;
        if (seg_n_o[27:21] !== 7'b1111111 || seg_n_o[6:0] !== 7'b0000001) begin
            errors++;
            $display("FAIL R1 actual=%b expected=1111111..0000001", seg_n_o);
        end
        // R2 and R3: every code in every position
        for (int v = 1; v < 16; v++) begin
            apply(1'b0, {4{4'(v)}});
            expect_row(v < 10 ? "R2" : "R3", 4'b1111);
        end
        // R4: zero with low blanking input goes dark
        apply(1'b0, 16'h0071);
        expect_row("R4", 4'b0011);
        // R5: zero with high blanking input shown
        apply(1'b0, 16'h3000);
        expect_row("R5", 4'b1111);
        // R6: nonzero at head of chain shown despite low input
        apply(1'b1, 16'h0002);
        expect_row("R6", 4'b1111);
        // R9: all zero, both modes
        apply(1'b0, 16'h0000);
        expect_row("R9", 4'b0000);
        apply(1'b1, 16'h0000);
        expect_row("R9", 4'b0000);
        // R10: internal zeros kept
        apply(1'b0, 16'h0904);
        expect_row("R10", 4'b0111);
        apply(1'b1, 16'h9040);
        expect_row("R10", 4'b1110);
        apply(1'b0, 16'h8001);
        expect_row("R10", 4'b1111);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule